// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a host-side configuration request port and the memory-style master port of a PCI Express root port. Each request names a bus, device, function and register offset, plus a read or write flag and write data. The block first checks that the topology address can exist. Impossible addresses are answered at once: a read returns all-ones and a write returns an error. In both cases nothing goes downstream.

For an address that can exist, the block sets a window type and a window target, which model the outbound translation window. It then issues one dword-aligned downstream access. Bus 0 is the root port itself, so those requests go to the local register window. Every other bus goes to a configuration slice at the top of the outbound window, and the translation target carries the packed routing ID.

Requests are served one at a time. The downstream access is watched by a cycle counter so that a target that never answers still produces a response.

Top module: `cfg_access_xlate`

## Requirements
- R1: A request is rejected when it is on bus 0 with a device number above 1, or on bus 1 with a device number other than 0. A rejected request makes no downstream access (`dn_valid` stays 0) and leaves `win_type` and `win_target` unchanged.
- R2: A rejected read gives `rsp_valid` in the cycle after acceptance, with `rsp_rdata` = 0xFFFFFFFF and `rsp_err` = 0.
- R3: A rejected write gives `rsp_valid` in the cycle after acceptance, with `rsp_err` = 1 and `rsp_rdata` = 0.
- R4: An accepted request on bus 0 or 1 sets `win_type` to 4 (type-0 configuration). An accepted request on bus 2 or above sets it to 5 (type-1). The new value is visible from the first cycle in which `dn_valid` is high.
- R5: A bus 0 request addresses `LOCAL_BASE` (default 0x01FFC000) plus the aligned offset, and leaves `win_target` unchanged.
- R6: A request on any other bus addresses the configuration slice base plus the aligned offset. With the defaults that base is 0x01F00000, the top 1 MB of the 16 MB window at 0x01000000. The request also sets `win_target` to bus in bits 31:24, device in bits 23:19, function in bits 18:16, and zero in bits 15:0.
- R7: The two low bits of the register offset are cleared, so `dn_addr[1:0]` is always 0 while `dn_valid` is high.
- R8: A read that `dn_ready` completes with `dn_err` = 0 returns `dn_rdata`. A read that completes with `dn_err` = 1 returns 0xFFFFFFFF with `rsp_err` = 0. A write that completes with `dn_err` = 1 gives `rsp_err` = 1. `rsp_rdata` is 0 for every write.
- R9: If `dn_ready` has not been seen after `TIMEOUT_CYC` cycles of `dn_valid`, the access ends anyway. A read then returns 0xFFFFFFFF with `rsp_err` = 0, and a write returns `rsp_err` = 1.
- R10: `req_ready` is low from acceptance until the cycle after the one-cycle `rsp_valid` pulse. While `dn_valid` is high without `dn_ready`, the following all hold: `dn_addr`, `win_type` and `win_target` stay stable, and `dn_valid` stays high unless the response follows.
- R11: After reset, `req_ready` = 1, `dn_valid` = 0, `rsp_valid` = 0, `win_type` = 4 and `win_target` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_ofs | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Downstream access active |
| dn_write | output | 1 | Downstream access is a write |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ready | input | 1 | Downstream access completes |
| dn_rdata | input | 32 | Downstream read data |
| dn_err | input | 1 | Downstream access aborted |
| win_type | output | 4 | Current window transaction type |
| win_target | output | 32 | Current window translation target |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 32 | Response read data |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 8 and keeps the default window bases. The short timeout makes both the read and the write timeout paths reachable within a few cycles per request, and the known bases give exact expected addresses for the local window and the configuration slice. The chosen bus and device values cover both topology filters and both type encodings. The offsets are deliberately misaligned to exercise the clearing of the low bits.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_RESP   = 2'd2
   } seq_state_e;

   localparam logic [3:0] TYPE_CFG_LOCAL = 4'd4;
   localparam logic [3:0] TYPE_CFG_FWD   = 4'd5;
endpackage

// File: rtl/cfg_topo_check.sv
module cfg_topo_check #(
   parameter int BUS_W        = 8,
   parameter int DEV_W        = 5,
   parameter int MAX_DEV_BUS0 = 1
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   output logic             ok
);
   logic bad_root, bad_link;

   // Bus 0 holds the root port and at most MAX_DEV_BUS0 + 1 devices.
   assign bad_root = (bus == '0) && (dev > DEV_W'(MAX_DEV_BUS0));
   // Bus 1 sits on a point-to-point link, so only device 0 can exist.
   assign bad_link = (bus == BUS_W'(1)) && (dev != '0);
   assign ok       = !(bad_root || bad_link);
endmodule

// File: rtl/cfg_addr_map.sv
module cfg_addr_map
   import cfg_xlate_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              BUS_W      = 8,
   parameter int              DEV_W      = 5,
   parameter int              FN_W       = 3,
   parameter int              OFS_W      = 12,
   parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0100_0000,
   parameter int              WIN_LOG2   = 24,
   parameter int              CFG_LOG2   = 20
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FN_W-1:0]   func,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] addr,
   output logic [3:0]        ttype,
   output logic [ADDR_W-1:0] target,
   output logic              is_local
);
   localparam int              ID_W     = BUS_W + DEV_W + FN_W;
   localparam int              ID_SHIFT = ADDR_W - ID_W;
   localparam logic [ADDR_W-1:0] CFG_BASE = WIN_BASE
                                          + (ADDR_W'(1) << WIN_LOG2)
                                          - (ADDR_W'(1) << CFG_LOG2);

   logic [ADDR_W-1:0] ofs_ext, ofs_dw;
   logic [ID_W-1:0]   rid;

   assign ofs_ext  = ADDR_W'(ofs);
   assign ofs_dw   = ofs_ext & ~ADDR_W'(3);
   assign is_local = (bus == '0);
   assign rid      = {bus, dev, func};
   assign target   = ADDR_W'(rid) << ID_SHIFT;
   assign ttype    = (bus < BUS_W'(2)) ? TYPE_CFG_LOCAL : TYPE_CFG_FWD;
   assign addr     = (is_local ? LOCAL_BASE : CFG_BASE) + ofs_dw;
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
   import cfg_xlate_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              topo_ok,
   output logic              req_ready,
   output logic              dn_valid,
   input  logic              dn_ready,
   input  logic              dn_err,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);
   seq_state_e state;
   logic       wr_q;
   logic       expire;

   assign req_ready = (state == ST_IDLE);
   assign dn_valid  = (state == ST_ACCESS);
   assign rsp_valid = (state == ST_RESP);

   generate
      if (TIMEOUT_CYC > 0) begin : g_timer
         localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt <= '0;
            else if (state != ST_ACCESS) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
         end
         assign expire = (cnt == CNT_W'(TIMEOUT_CYC - 1));
      end else begin : g_no_timer
         assign expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         wr_q      <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               wr_q <= req_write;
               if (topo_ok) begin
                  state <= ST_ACCESS;
               end else begin
                  state     <= ST_RESP;
                  rsp_err   <= req_write;
                  rsp_rdata <= req_write ? '0 : '1;
               end
            end
            ST_ACCESS: if (dn_ready) begin
               state     <= ST_RESP;
               rsp_err   <= wr_q & dn_err;
               rsp_rdata <= wr_q ? '0 : (dn_err ? '1 : dn_rdata);
            end else if (expire) begin
               state     <= ST_RESP;
               rsp_err   <= wr_q;
               rsp_rdata <= wr_q ? '0 : '1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
   import cfg_xlate_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter int                DATA_W       = 32,
   parameter int                BUS_W        = 8,
   parameter int                DEV_W        = 5,
   parameter int                FN_W         = 3,
   parameter int                OFS_W        = 12,
   parameter int                MAX_DEV_BUS0 = 1,
   parameter logic [ADDR_W-1:0] LOCAL_BASE   = 32'h01FF_C000,
   parameter logic [ADDR_W-1:0] WIN_BASE     = 32'h0100_0000,
   parameter int                WIN_LOG2     = 24,
   parameter int                CFG_LOG2     = 20,
   parameter int                TIMEOUT_CYC  = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_func,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              dn_valid,
   output logic              dn_write,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_ready,
   input  logic [DATA_W-1:0] dn_rdata,
   input  logic              dn_err,
   output logic [3:0]        win_type,
   output logic [ADDR_W-1:0] win_target,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);
   generate
      if (ADDR_W < BUS_W + DEV_W + FN_W) begin : g_bad_id
         $error("routing ID does not fit in the address width");
      end
      if (CFG_LOG2 >= WIN_LOG2 || WIN_LOG2 >= ADDR_W) begin : g_bad_win
         $error("configuration slice must lie inside the window");
      end
      if (OFS_W < 3 || TIMEOUT_CYC < 0) begin : g_bad_misc
         $error("offset width or timeout out of range");
      end
   endgenerate

   logic              topo_ok, map_local, accept;
   logic [ADDR_W-1:0] map_addr, map_target;
   logic [3:0]        map_type;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              write_q;

   cfg_topo_check #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .MAX_DEV_BUS0(MAX_DEV_BUS0)
   ) i_topo (
      .bus(req_bus), .dev(req_dev), .ok(topo_ok)
   );

   cfg_addr_map #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
      .OFS_W(OFS_W), .LOCAL_BASE(LOCAL_BASE), .WIN_BASE(WIN_BASE),
      .WIN_LOG2(WIN_LOG2), .CFG_LOG2(CFG_LOG2)
   ) i_map (
      .bus(req_bus), .dev(req_dev), .func(req_func), .ofs(req_ofs),
      .addr(map_addr), .ttype(map_type), .target(map_target),
      .is_local(map_local)
   );

   cfg_seq #(
      .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) i_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .topo_ok(topo_ok),
      .req_ready(req_ready), .dn_valid(dn_valid), .dn_ready(dn_ready),
      .dn_err(dn_err), .dn_rdata(dn_rdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   assign accept = req_valid && req_ready;

   // The window is reprogrammed at the accepting edge, so it is already
   // in place when the access is first presented downstream.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_type   <= TYPE_CFG_LOCAL;
         win_target <= '0;
         addr_q     <= '0;
         wdata_q    <= '0;
         write_q    <= 1'b0;
      end else if (accept && topo_ok) begin
         win_type <= map_type;
         if (!map_local) win_target <= map_target;
         addr_q  <= map_addr;
         wdata_q <= req_wdata;
         write_q <= req_write;
      end
   end

   assign dn_addr  = addr_q;
   assign dn_wdata = wdata_q;
   assign dn_write = write_q;
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int TIMEOUT_CYC = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [ADDR_W-1:0] dn_addr,
   input logic [3:0]        win_type,
   input logic [ADDR_W-1:0] win_target,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata
);
   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_len <= 0;
      else if (dn_valid) run_len <= run_len + 1;
      else               run_len <= 0;
   end

   // R7
   dw_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_addr[1:0] == 2'b00);

   // R4
   type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (win_type == 4'd4 || win_type == 4'd5));

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> rsp_valid ||
         (dn_valid && $stable(dn_addr) && $stable(win_type) && $stable(win_target)));

   // R10
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid || rsp_valid) |-> !req_ready);

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R2
   reject_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && req_ready && !req_write))
         |-> (rsp_rdata == '1 && !rsp_err));

   // R3
   reject_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && req_ready && req_write)) |-> rsp_err);

   // R9
   timeout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (TIMEOUT_CYC == 0 || run_len < TIMEOUT_CYC));
endmodule

bind cfg_access_xlate cfg_xlate_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .dn_valid(dn_valid), .dn_ready(dn_ready),
   .dn_addr(dn_addr), .win_type(win_type), .win_target(win_target),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/test_cfg_access_xlate.sv
module test_cfg_access_xlate;
   localparam int TO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_ofs = '0;
   logic [31:0] req_wdata = '0;
   logic        dn_ready = 1'b0, dn_err = 1'b0;
   logic [31:0] dn_rdata = '0;
   logic        req_ready, dn_valid, dn_write, rsp_valid, rsp_err;
   logic [31:0] dn_addr, dn_wdata, win_target, rsp_rdata;
   logic [3:0]  win_type;

   int n_chk = 0, n_bad = 0;
   logic [3:0]  m_type   = 4'd4;
   logic [31:0] m_target = 32'h0;
   bit          done = 0;

   always #10 clk = ~clk;

   cfg_access_xlate #(.TIMEOUT_CYC(TO)) i_cfg_access_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev),
      .req_func(req_func), .req_ofs(req_ofs), .req_wdata(req_wdata),
      .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
      .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rdata(dn_rdata),
      .dn_err(dn_err), .win_type(win_type), .win_target(win_target),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Behavioural model of one transaction, compared cycle by cycle.
   task automatic xfer(bit wr, logic [7:0] bus, logic [4:0] dev, logic [2:0] fn,
                       logic [11:0] ofs, logic [31:0] wd, int delay, bit abrt,
                       logic [31:0] rd);
      bit ok;
      logic [31:0] e_addr, e_data;
      bit e_err;
      ok = !((bus == 0 && dev > 1) || (bus == 1 && dev != 0));
      e_addr = ((bus == 0) ? 32'h01FF_C000 : 32'h01F0_0000) + {20'h0, ofs & 12'hFFC};
      if (!ok) begin
         e_data = wr ? 32'h0 : 32'hFFFF_FFFF; e_err = wr;
      end else if (delay >= TO || abrt) begin
         e_data = wr ? 32'h0 : 32'hFFFF_FFFF; e_err = wr;
      end else begin
         e_data = wr ? 32'h0 : rd; e_err = 1'b0;
      end
      @(negedge clk);
      chk("R10 idle ready", {31'h0, req_ready}, 32'h1);
      req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
      req_func = fn; req_ofs = ofs; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      if (!ok) begin
         chk("R1 no downstream", {31'h0, dn_valid}, 32'h0);
         chk("R1 type kept", {28'h0, win_type}, {28'h0, m_type});
         chk("R1 target kept", win_target, m_target);
         chk("R2/R3 rsp_valid", {31'h0, rsp_valid}, 32'h1);
         chk(wr ? "R3 err" : "R2 err", {31'h0, rsp_err}, {31'h0, e_err});
         chk(wr ? "R3 data" : "R2 data", rsp_rdata, e_data);
      end else begin
         m_type = (bus < 2) ? 4'd4 : 4'd5;
         if (bus != 0) m_target = {bus, dev, fn, 16'h0};
         for (int k = 0; k < 1000; k++) begin
            chk("R10 dn_valid held", {31'h0, dn_valid}, 32'h1);
            chk("R10 busy", {31'h0, req_ready}, 32'h0);
            chk("R5/R6/R7 addr", dn_addr, e_addr);
            chk("R4 type", {28'h0, win_type}, {28'h0, m_type});
            chk("R5/R6 target", win_target, m_target);
            chk("R8 write flag", {31'h0, dn_write}, {31'h0, wr});
            if (wr) chk("R8 wdata", dn_wdata, wd);
            dn_ready = (k == delay); dn_err = abrt; dn_rdata = rd;
            if (k == delay || k == TO - 1) break;
            @(negedge clk);
         end
         @(negedge clk);
         dn_ready = 1'b0; dn_err = 1'b0;
         chk("R9 access ended", {31'h0, dn_valid}, 32'h0);
         chk("R8/R9 rsp_valid", {31'h0, rsp_valid}, 32'h1);
         chk("R8/R9 err", {31'h0, rsp_err}, {31'h0, e_err});
         chk("R8/R9 data", rsp_rdata, e_data);
      end
      @(negedge clk);
      chk("R10 single pulse", {31'h0, rsp_valid}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 req_ready", {31'h0, req_ready}, 32'h1);
      chk("R11 dn_valid", {31'h0, dn_valid}, 32'h0);
      chk("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk("R11 win_type", {28'h0, win_type}, 32'h4);
      chk("R11 win_target", win_target, 32'h0);
      rst_n = 1'b1;
      // R5 R8 local read, immediate ready
      xfer(0, 8'd0, 5'd0, 3'd0, 12'h010, 32'h0, 0, 0, 32'h1234_5678);
      // R7 misaligned offset on local window
      xfer(0, 8'd0, 5'd1, 3'd2, 12'h007, 32'h0, 1, 0, 32'hA5A5_0001);
      // R6 R4 bus 1 write, type-0
      xfer(1, 8'd1, 5'd0, 3'd3, 12'h102, 32'hCAFE_0102, 2, 0, 32'h0);
      // R6 R4 bus 5 read, type-1, packed target
      xfer(0, 8'd5, 5'd17, 3'd6, 12'h3FF, 32'h0, 1, 0, 32'h0BAD_F00D);
      // R5 bus 0 keeps target
      xfer(0, 8'd0, 5'd1, 3'd0, 12'h020, 32'h0, 0, 0, 32'h0000_0020);
      // R1 R2 rejected read
      xfer(0, 8'd0, 5'd2, 3'd0, 12'h000, 32'h0, 0, 0, 32'h0);
      // R1 R3 rejected write
      xfer(1, 8'd1, 5'd3, 3'd1, 12'h004, 32'h1111_2222, 0, 0, 32'h0);
      // R8 aborted read
      xfer(0, 8'd2, 5'd0, 3'd0, 12'h008, 32'h0, 0, 1, 32'h5555_5555);
      // R8 aborted write
      xfer(1, 8'd2, 5'd4, 3'd1, 12'h00C, 32'h7777_0000, 1, 1, 32'h0);
      // R9 read timeout
      xfer(0, 8'd3, 5'd1, 3'd0, 12'h040, 32'h0, 100, 0, 32'h0);
      // R9 write timeout
      xfer(1, 8'd4, 5'd31, 3'd7, 12'hFFD, 32'h0000_ABCD, 100, 0, 32'h0);
      // R9 ready on the last allowed cycle still completes normally
      xfer(0, 8'd6, 5'd2, 3'd1, 12'h0F0, 32'h0, TO - 1, 0, 32'h6666_0F0F);
      done = 1;
      summary();
   end
endmodule